// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits between a 32-bit host access port and an internal register file. The register file holds three kinds of target: 128-bit control registers, 64-bit SRAM words and plain 32-bit registers. Host writes arrive one dword at a time. For a wide target, the block gathers them in a collector and issues one full-width commit once the target is complete. A plain 32-bit register is passed straight through.

Two write-only descriptor-pointer registers are repeated in every page-mapped block and follow a looser rule. A write to the top dword of either one always commits it. Any low dword that has not been gathered is committed as zero. A low-dword write to one of these registers is dropped while the collector is busy with another register. A write to the timer command register in page 0 flushes whatever the collector holds. Reads pass through combinationally, one dword per access. The descriptor-pointer registers read as zero.

Top module: `wide_write_collector`

## Requirements
- R1: A 128-bit control register (page offset below 0x400, outside the SRAM window) commits only when all four of its dwords (offsets 0, 4, 8, 12; offset 12 is bits 127:96) have been written, in any order. The commit is issued in the same cycle as the final write, with cm_size = 2 and cm_addr = the 16-byte base, and the collector is then empty.
- R2: An SRAM word (address bit 23 set) commits when both of its dwords have arrived, with cm_size = 1, cm_addr = the 8-byte base, the data in bits 63:0 and zero above. A write to a different SRAM word restarts the collection.
- R3: A write to any other offset is a plain 32-bit write. It appears on the commit port in the same cycle with cm_size = 0, cm_addr = the write address and the data in bits 31:0, and it leaves the collector unchanged.
- R4: For a 128-bit control register, a write to a register other than the one being collected discards the earlier partial contents and starts a new collection.
- R5: A write to the top dword of a descriptor-pointer register (page offsets 0x83C and 0xA1C) always commits that register with cm_size = 2. Low dwords it holds from earlier writes are included, and the rest are zero.
- R6: A low-dword write to a descriptor-pointer register is dropped while the collector holds dwords of another register, and the collector keeps its contents.
- R7: Addresses are the page number times 0x2000 plus the page offset. The same offset in two pages is two distinct registers.
- R8: A write to offset 0x420 of page 0 is written through and empties the collector. The same offset in any other page is only written through.
- R9: A read presents rd_addr on rf_rd_addr and returns rf_rd_data in the same cycle, except that addresses inside a descriptor-pointer register return zero.
- R10: Reset empties the collector. No commit is issued without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host dword write strobe |
| wr_addr | input | 24 | Host byte address of the write |
| wr_data | input | 32 | Host write data |
| cm_valid | output | 1 | Commit strobe to the register file |
| cm_size | output | 2 | Commit width: 0 = 32, 1 = 64, 2 = 128 bits |
| cm_addr | output | 24 | Commit target base address |
| cm_data | output | 128 | Commit data |
| rd_addr | input | 24 | Host read address |
| rf_rd_addr | output | 24 | Address forwarded to the register file |
| rf_rd_data | input | 32 | Register file read data |
| rd_data | output | 32 | Host read data |

## Verification
The assertions check four things on every cycle: that there is no commit without a write, that the collector is empty after each wide commit and after a page-0 timer write, that plain writes to other addresses leave the valid mask untouched, and that SRAM commits carry zero in their upper half. The assembled data needs the bench's scenarios: the dword order, the zero fill of descriptor commits, dropped low writes, restarts on a foreign register and page separation all depend on the sequence of writes that came before.

// File: rtl/wide_write_collector.sv
module wide_write_collector #(
  parameter int AW         = 24,
  parameter int OFW        = 13,
  parameter int WIDE_LIMIT = 'h400,
  parameter int DESC_A     = 'h830,
  parameter int DESC_B     = 'hA10,
  parameter int TIMER_OFS  = 'h420
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  output logic           cm_valid,
  output logic [1:0]     cm_size,
  output logic [AW-1:0]  cm_addr,
  output logic [127:0]   cm_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [AW-1:0]  rf_rd_addr,
  input  logic [31:0]    rf_rd_data,
  output logic [31:0]    rd_data
);
  localparam int BW = AW - 3;
  localparam logic [OFW-5:0] DA = OFW'(DESC_A) >> 4;
  localparam logic [OFW-5:0] DB = OFW'(DESC_B) >> 4;
  localparam logic [AW-1:0] TIMER0 = AW'(TIMER_OFS);

  typedef enum logic [1:0] {K_PLAIN, K_WIDE, K_SRAM, K_DESC} kind_t;

  function automatic kind_t kind_of(input logic [AW-1:0] a);
    logic [OFW-1:0] o;
    o = a[OFW-1:0];
    if (a[AW-1]) return K_SRAM;
    if (o[OFW-1:4] == DA || o[OFW-1:4] == DB) return K_DESC;
    if (32'(o) < WIDE_LIMIT) return K_WIDE;
    return K_PLAIN;
  endfunction

  logic [3:0]       col_valid;
  logic [3:0][31:0] col_data;
  logic [BW-1:0]    col_base;
  kind_t            col_kind;

  logic [3:0]       nxt_valid;
  logic [3:0][31:0] nxt_data;
  logic [BW-1:0]    nxt_base;
  kind_t            nxt_kind;

  kind_t            wkind;
  logic [BW-1:0]    wbase;
  logic [1:0]       widx;
  logic             hit;
  logic [3:0]       mv;
  logic [3:0][31:0] md;

  assign wkind = kind_of(wr_addr);
  assign wbase = {wr_addr[AW-1:4], wr_addr[3] & (wkind == K_SRAM)};
  assign widx  = (wkind == K_SRAM) ? {1'b0, wr_addr[2]} : wr_addr[3:2];
  assign hit   = (|col_valid) && col_kind == wkind && col_base == wbase;

  always_comb begin
    mv = (hit ? col_valid : 4'b0) | (4'b1 << widx);
    md = col_data;
    md[widx] = wr_data;
    for (int i = 0; i < 4; i++)
      if (!mv[i]) md[i] = '0;
  end

  always_comb begin
    nxt_valid = col_valid;
    nxt_data  = col_data;
    nxt_base  = col_base;
    nxt_kind  = col_kind;
    cm_valid  = 1'b0;
    cm_size   = 2'd0;
    cm_addr   = '0;
    cm_data   = '0;
    if (wr_en) begin
      unique case (wkind)
        K_PLAIN: begin
          cm_valid = 1'b1;
          cm_addr  = wr_addr;
          cm_data  = {96'b0, wr_data};
          if (wr_addr == TIMER0) nxt_valid = '0;
        end
        K_WIDE, K_SRAM: begin
          if ((wkind == K_WIDE && &mv) || (wkind == K_SRAM && &mv[1:0])) begin
            cm_valid  = 1'b1;
            cm_size   = (wkind == K_WIDE) ? 2'd2 : 2'd1;
            cm_addr   = {wbase, 3'b000};
            cm_data   = (wkind == K_WIDE) ? md : {64'b0, md[1], md[0]};
            nxt_valid = '0;
          end else begin
            nxt_valid = mv;
            nxt_data  = md;
            nxt_base  = wbase;
            nxt_kind  = wkind;
          end
        end
        K_DESC: begin
          if (widx == 2'd3) begin
            cm_valid  = 1'b1;
            cm_size   = 2'd2;
            cm_addr   = {wbase, 3'b000};
            cm_data   = md;
            nxt_valid = '0;
          end else if (col_valid == '0 || hit) begin
            nxt_valid = mv;
            nxt_data  = md;
            nxt_base  = wbase;
            nxt_kind  = wkind;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_valid <= '0;
      col_data  <= '0;
      col_base  <= '0;
      col_kind  <= K_PLAIN;
    end else begin
      col_valid <= nxt_valid;
      col_data  <= nxt_data;
      col_base  <= nxt_base;
      col_kind  <= nxt_kind;
    end
  end

  assign rf_rd_addr = rd_addr;
  assign rd_data    = (kind_of(rd_addr) == K_DESC) ? 32'b0 : rf_rd_data;
endmodule

module wide_write_collector_chk #(
  parameter int AW        = 24,
  parameter int TIMER_OFS = 'h420
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          cm_valid,
  input logic [1:0]    cm_size,
  input logic [AW-1:0] cm_addr,
  input logic [127:0]  cm_data,
  input logic [3:0]    col_valid
);
  localparam logic [AW-1:0] TIMER0 = AW'(TIMER_OFS);

  AST_NO_SPURIOUS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> !cm_valid); // R10
  AST_EMPTY_AFTER_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_size != 2'd0) |=> col_valid == 4'b0); // R1
  AST_PLAIN_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_size == 2'd0 && cm_addr != TIMER0) |=> col_valid == $past(col_valid)); // R3
  AST_SRAM_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && cm_size == 2'd1) |-> cm_data[127:64] == 64'b0); // R2
  AST_TIMER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == TIMER0) |=> col_valid == 4'b0); // R8
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> cm_size != 2'd3); // R1
endmodule

bind wide_write_collector wide_write_collector_chk #(.AW(AW), .TIMER_OFS(TIMER_OFS)) u_chk (.*);

// File: tb/tb_wide_write_collector.sv
module tb_wide_write_collector;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [23:0]  wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         cm_valid;
  logic [1:0]   cm_size;
  logic [23:0]  cm_addr;
  logic [127:0] cm_data;
  logic [23:0]  rd_addr = '0;
  logic [23:0]  rf_rd_addr;
  logic [31:0]  rf_rd_data = '0;
  logic [31:0]  rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wide_write_collector dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cm_valid(cm_valid), .cm_size(cm_size), .cm_addr(cm_addr), .cm_data(cm_data),
    .rd_addr(rd_addr), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [3:0]   rq;
    logic [23:0]  a;
    logic [31:0]  d;
    logic         v;
    logic [1:0]   sz;
    logic [23:0]  ca;
    logic [127:0] cd;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  24'h000010, 32'hAAAA0000, 1'b0, 2'd0, 24'h0, 128'h0},   // R1
    '{4'd1,  24'h00001C, 32'hAAAA0003, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd1,  24'h000014, 32'hAAAA0001, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd3,  24'h000404, 32'h11111111, 1'b1, 2'd0, 24'h000404, 128'h11111111}, // R3
    '{4'd1,  24'h000018, 32'hAAAA0002, 1'b1, 2'd2, 24'h000010,
      128'hAAAA0003_AAAA0002_AAAA0001_AAAA0000},
    '{4'd2,  24'h800008, 32'h55550000, 1'b0, 2'd0, 24'h0, 128'h0},   // R2
    '{4'd2,  24'h80000C, 32'h55550001, 1'b1, 2'd1, 24'h800008, 128'h55550001_55550000},
    '{4'd5,  24'h002830, 32'hD0D0D0D0, 1'b0, 2'd0, 24'h0, 128'h0},   // R5
    '{4'd5,  24'h002838, 32'hD2D2D2D2, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd5,  24'h00283C, 32'hD3D3D3D3, 1'b1, 2'd2, 24'h002830,
      128'hD3D3D3D3_D2D2D2D2_00000000_D0D0D0D0},
    '{4'd5,  24'h00283C, 32'hE3E3E3E3, 1'b1, 2'd2, 24'h002830, 128'hE3E3E3E3_00000000_00000000_00000000},
    '{4'd6,  24'h000020, 32'hB0B0B0B0, 1'b0, 2'd0, 24'h0, 128'h0},   // R6
    '{4'd6,  24'h002A10, 32'hF0F0F0F0, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd6,  24'h000024, 32'hB1B1B1B1, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd6,  24'h000028, 32'hB2B2B2B2, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd6,  24'h00002C, 32'hB3B3B3B3, 1'b1, 2'd2, 24'h000020,
      128'hB3B3B3B3_B2B2B2B2_B1B1B1B1_B0B0B0B0},
    '{4'd4,  24'h000030, 32'hC0C0C0C0, 1'b0, 2'd0, 24'h0, 128'h0},   // R4
    '{4'd4,  24'h000034, 32'hC1C1C1C1, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd4,  24'h000040, 32'h60606060, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd4,  24'h000038, 32'hC2C2C2C2, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd4,  24'h00003C, 32'hC3C3C3C3, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd4,  24'h000030, 32'h0C0C0C0C, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd4,  24'h000034, 32'h1C1C1C1C, 1'b1, 2'd2, 24'h000030,
      128'hC3C3C3C3_C2C2C2C2_1C1C1C1C_0C0C0C0C},
    '{4'd8,  24'h000050, 32'h50505050, 1'b0, 2'd0, 24'h0, 128'h0},   // R8
    '{4'd8,  24'h000054, 32'h51515151, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000058, 32'h52525252, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h002420, 32'h77777777, 1'b1, 2'd0, 24'h002420, 128'h77777777},
    '{4'd8,  24'h00005C, 32'h53535353, 1'b1, 2'd2, 24'h000050,
      128'h53535353_52525252_51515151_50505050},
    '{4'd8,  24'h000060, 32'h60000000, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000064, 32'h60000001, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000068, 32'h60000002, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000420, 32'h88888888, 1'b1, 2'd0, 24'h000420, 128'h88888888},
    '{4'd8,  24'h00006C, 32'h60000003, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000060, 32'h61000000, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000064, 32'h61000001, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd8,  24'h000068, 32'h61000002, 1'b1, 2'd2, 24'h000060,
      128'h60000003_61000002_61000001_61000000},
    '{4'd7,  24'h002830, 32'h4B4B4B4B, 1'b0, 2'd0, 24'h0, 128'h0},   // R7
    '{4'd7,  24'h004838, 32'h9A9A9A9A, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd7,  24'h00483C, 32'h9B9B9B9B, 1'b1, 2'd2, 24'h004830, 128'h9B9B9B9B_00000000_00000000_00000000},
    '{4'd7,  24'h00283C, 32'h9C9C9C9C, 1'b1, 2'd2, 24'h002830, 128'h9C9C9C9C_00000000_00000000_00000000},
    '{4'd2,  24'h800010, 32'h12340000, 1'b0, 2'd0, 24'h0, 128'h0},   // R2 restart
    '{4'd2,  24'h800018, 32'h56780000, 1'b0, 2'd0, 24'h0, 128'h0},
    '{4'd2,  24'h80001C, 32'h5678FFFF, 1'b1, 2'd1, 24'h800018, 128'h5678FFFF_56780000}
  };

  task automatic check(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, output logic v,
                    output logic [1:0] sz, output logic [23:0] ca, output logic [127:0] cd);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    #1;
    v = cm_valid; sz = cm_size; ca = cm_addr; cd = cm_data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  initial begin
    logic v; logic [1:0] sz; logic [23:0] ca; logic [127:0] cd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(cm_valid == 1'b0, "R10 reset idle", 128'(cm_valid), 128'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i].a, VEC[i].d, v, sz, ca, cd);
      check(v == VEC[i].v, $sformatf("R%0d vec%0d valid", VEC[i].rq, i), 128'(v), 128'(VEC[i].v));
      if (VEC[i].v) begin
        check(sz == VEC[i].sz, $sformatf("R%0d vec%0d size", VEC[i].rq, i), 128'(sz), 128'(VEC[i].sz));
        check(ca == VEC[i].ca, $sformatf("R%0d vec%0d addr", VEC[i].rq, i), 128'(ca), 128'(VEC[i].ca));
        check(cd == VEC[i].cd, $sformatf("R%0d vec%0d data", VEC[i].rq, i), cd, VEC[i].cd);
      end
    end

    // R10: reset in the middle of a collection empties it
    wr(24'h000070, 32'h70, v, sz, ca, cd);
    wr(24'h000074, 32'h74, v, sz, ca, cd);
    wr(24'h000078, 32'h78, v, sz, ca, cd);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    wr(24'h00007C, 32'h7C, v, sz, ca, cd);
    check(v == 1'b0, "R10 mid reset flush", 128'(v), 128'h0);
    wr(24'h000070, 32'h70, v, sz, ca, cd);
    wr(24'h000074, 32'h74, v, sz, ca, cd);
    wr(24'h000078, 32'h78, v, sz, ca, cd);
    check(v == 1'b1 && cd == 128'h7C_00000078_00000074_00000070, "R10 R1 rebuild", cd,
          128'h7C_00000078_00000074_00000070);

    // R9: reads
    @(negedge clk);
    rd_addr = 24'h000010; rf_rd_data = 32'hCAFEF00D;
    #1;
    check(rf_rd_addr == 24'h000010, "R9 addr forward", 128'(rf_rd_addr), 128'h10);
    check(rd_data == 32'hCAFEF00D, "R9 data pass", 128'(rd_data), 128'hCAFEF00D);
    @(negedge clk);
    rd_addr = 24'h002A14;
    #1;
    check(rd_data == 32'h0, "R9 descriptor reads zero", 128'(rd_data), 128'h0);
    @(negedge clk);
    rd_addr = 24'h80000C; rf_rd_data = 32'h0BADBEEF;
    #1;
    check(rd_data == 32'h0BADBEEF, "R9 sram read", 128'(rd_data), 128'h0BADBEEF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule